// File: doc/BRIEF.md
# Timing-Qualified I2C Start/Stop Condition Detector

This block watches the two I2C bus lines and tells the rest of a serial controller when a START or a STOP condition has taken place. An SDA transition while SCL is high is accepted only if the bus timing around it is plausible. SCL must have been high long enough beforehand (release time). SDA must have been steady long enough before it moved (setup time). SCL must then stay high long enough after the move (hold time). All three are measured in system clock cycles. Each minimum has two values, one for standard timing and one for high-speed timing, and a mode input picks between them.

Both bus lines pass through two-flop synchronizers before any edge detection or counting. An accepted condition produces a single-cycle pulse on `start_pulse` or `stop_pulse` once its hold time has been met. A STOP seen while the controller runs as a slave also sets a level interrupt request, which stays set until software-side logic strobes `irq_clear`. The block does not shift data, drive the bus, match addresses or generate acknowledges.

Top module: `i2c_cond_qualifier`

## Requirements
- R1: During reset and on the first cycles after it, `start_pulse`, `stop_pulse` and `irq` are 0.
- R2: A START is SDA going 1 to 0 while SCL is 1. SDA changes while SCL is 0 never produce a pulse.
- R3: A candidate is rejected unless SCL has been high for more than the release minimum: 26 cycles in standard mode (`fast_mode`=0) and 4 cycles in high-speed mode (`fast_mode`=1). This is counted from the SCL rise to the SDA edge.
- R4: A candidate is rejected unless SDA has been steady for more than the setup minimum before its edge: 13 cycles in standard mode and 2 in high-speed mode. The count runs from the later of the SCL rise and the previous SDA change.
- R5: A candidate produces a pulse only if SCL stays high for more than the hold minimum after the SDA edge: 13 cycles in standard mode and 2 in high-speed mode. An earlier SCL fall cancels it silently.
- R6: A STOP is SDA going 0 to 1 while SCL is 1, qualified by the same three rules as a START.
- R7: Each pulse is exactly one cycle wide, and `start_pulse` and `stop_pulse` are never high together.
- R8: An accepted STOP while `is_master`=0 sets `irq` on the cycle after the stop pulse. A STOP while `is_master`=1, or any START, leaves `irq` unchanged.
- R9: `irq` holds its value until `irq_clear` is 1 on a clock edge. A clear on the same edge as a new set loses to the set.
- R10: The elapsed-time counters saturate, so an arbitrarily long SCL high time still meets the release and setup minimums.
- R11: If SDA changes again while a candidate is waiting for its hold time, the pending candidate is dropped. The new edge is then judged as a candidate of its own.
- R12: With inputs changing between clock edges, an accepted pulse is high for the clock period that follows the (hold minimum + 3)rd rising edge after the raw SDA change. This delay is two synchronizer stages plus the hold count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all timing is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| fast_mode | input | 1 | 0 selects standard minimums, 1 selects high-speed minimums |
| is_master | input | 1 | 1 while the controller acts as bus master |
| irq_clear | input | 1 | Clears the interrupt request |
| start_pulse | output | 1 | One-cycle pulse for an accepted START |
| stop_pulse | output | 1 | One-cycle pulse for an accepted STOP |
| irq | output | 1 | Level interrupt request for a STOP seen in slave mode |

## Verification
The properties watched on every cycle are the shape of the outputs. They check single-cycle, mutually exclusive pulses and a START pulse only after SCL was high. They check that the interrupt rises only after a slave-mode STOP, holds until cleared and drops on a clear. Whether the cycle-count thresholds sit exactly at their boundaries in both modes, whether a revert of SDA cancels and then requalifies, whether counters saturate, and the exact pulse latency can only be shown by the bench's scenarios. These scenarios place edges one cycle either side of each minimum.

// File: rtl/i2c_cq_pkg.sv
package i2c_cq_pkg;
  typedef enum logic { CQ_IDLE, CQ_HOLD } cq_state_e;
  typedef enum logic { CQ_START, CQ_STOP } cq_kind_e;
endpackage

// File: rtl/cq_sync.sv
// Multi-bit, multi-stage level synchronizer; each bit has its own chain.
module cq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/cq_sat_count.sv
// Elapsed-cycle counter: clear wins, then load-one, otherwise count up and stick at all ones.
module cq_sat_count #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load_one,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (clr)        q <= '0;
    else if (load_one)   q <= W'(1);
    else if (q != TOP)   q <= q + W'(1);
  end
endmodule

// File: rtl/cq_qualifier.sv
// Judges each SDA edge against release/setup minimums, then waits out the hold minimum.
module cq_qualifier
  import i2c_cq_pkg::*;
#(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scl_s,
  input  logic         scl_p,
  input  logic         sda_s,
  input  logic         sda_p,
  input  logic [W-1:0] rel_cnt,
  input  logic [W-1:0] stb_cnt,
  input  logic [W-1:0] rel_min,
  input  logic [W-1:0] stp_min,
  input  logic [W-1:0] hld_min,
  output logic         start_o,
  output logic         stop_o
);
  cq_state_e   state;
  cq_kind_e    kind;
  logic [W-1:0] hold_cnt;
  logic         sda_edge;
  logic         timing_ok;

  assign sda_edge  = (sda_s != sda_p);
  assign timing_ok = scl_s && scl_p && (rel_cnt > rel_min) && (stb_cnt > stp_min);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CQ_IDLE;
      kind     <= CQ_START;
      hold_cnt <= '0;
      start_o  <= 1'b0;
      stop_o   <= 1'b0;
    end else begin
      start_o <= 1'b0;
      stop_o  <= 1'b0;
      if (sda_edge) begin
        if (timing_ok) begin
          state    <= CQ_HOLD;
          kind     <= sda_s ? CQ_STOP : CQ_START;
          hold_cnt <= W'(1);
        end else begin
          state <= CQ_IDLE;
        end
      end else if (state == CQ_HOLD) begin
        if (!scl_s) begin
          state <= CQ_IDLE;
        end else if (hold_cnt >= hld_min) begin
          state   <= CQ_IDLE;
          start_o <= (kind == CQ_START);
          stop_o  <= (kind == CQ_STOP);
        end else begin
          hold_cnt <= hold_cnt + W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/i2c_cond_qualifier.sv
module i2c_cond_qualifier #(
  parameter int STD_REL     = 26,
  parameter int STD_SETUP   = 13,
  parameter int STD_HOLD    = 13,
  parameter int FAST_REL    = 4,
  parameter int FAST_SETUP  = 2,
  parameter int FAST_HOLD   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic fast_mode,
  input  logic is_master,
  input  logic irq_clear,
  output logic start_pulse,
  output logic stop_pulse,
  output logic irq
);
  localparam int MAX_A   = (STD_REL > FAST_REL) ? STD_REL : FAST_REL;
  localparam int MAX_B   = (STD_SETUP > STD_HOLD) ? STD_SETUP : STD_HOLD;
  localparam int MAX_C   = (FAST_SETUP > FAST_HOLD) ? FAST_SETUP : FAST_HOLD;
  localparam int MAX_BC  = (MAX_B > MAX_C) ? MAX_B : MAX_C;
  localparam int MAX_LIM = (MAX_A > MAX_BC) ? MAX_A : MAX_BC;
  localparam int CNT_W   = $clog2(MAX_LIM + 2);

  logic [1:0]       line_s;
  logic             scl_s, sda_s, scl_p, sda_p;
  logic [CNT_W-1:0] rel_cnt, stb_cnt;
  logic [CNT_W-1:0] rel_min, stp_min, hld_min;

  cq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b0;
      sda_p <= 1'b0;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign rel_min = fast_mode ? CNT_W'(FAST_REL)   : CNT_W'(STD_REL);
  assign stp_min = fast_mode ? CNT_W'(FAST_SETUP) : CNT_W'(STD_SETUP);
  assign hld_min = fast_mode ? CNT_W'(FAST_HOLD)  : CNT_W'(STD_HOLD);

  // Cycles since SCL rose.
  cq_sat_count #(.W(CNT_W)) u_rel (
    .clk(clk), .rst_n(rst_n), .clr(!scl_s), .load_one(1'b0), .q(rel_cnt)
  );
  // Cycles since the later of SCL rise and the last SDA change.
  cq_sat_count #(.W(CNT_W)) u_stb (
    .clk(clk), .rst_n(rst_n), .clr(!scl_s), .load_one(sda_s != sda_p), .q(stb_cnt)
  );

  cq_qualifier #(.W(CNT_W)) u_qual (
    .clk(clk), .rst_n(rst_n),
    .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s), .sda_p(sda_p),
    .rel_cnt(rel_cnt), .stb_cnt(stb_cnt),
    .rel_min(rel_min), .stp_min(stp_min), .hld_min(hld_min),
    .start_o(start_pulse), .stop_o(stop_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       irq <= 1'b0;
    else if (stop_pulse && !is_master) irq <= 1'b1;
    else if (irq_clear)                irq <= 1'b0;
  end
endmodule

// File: rtl/i2c_cq_checker.sv
module i2c_cq_checker (
  input logic clk,
  input logic rst_n,
  input logic is_master,
  input logic irq_clear,
  input logic start_pulse,
  input logic stop_pulse,
  input logic irq,
  input logic scl_s
);
  p_start_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  p_stop_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !stop_pulse);
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && stop_pulse));
  p_start_scl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(scl_s));
  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(stop_pulse && !is_master));
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clear) |=> irq);
  p_irq_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !stop_pulse) |=> !irq);
endmodule

bind i2c_cond_qualifier i2c_cq_checker u_cq_checker (
  .clk(clk), .rst_n(rst_n), .is_master(is_master), .irq_clear(irq_clear),
  .start_pulse(start_pulse), .stop_pulse(stop_pulse), .irq(irq), .scl_s(scl_s)
);

// File: tb/test_i2c_cond_qualifier.sv
`timescale 1ns/1ps
module test_i2c_cond_qualifier;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b0, sda = 1'b1, fast_mode = 1'b0, is_master = 1'b0, irq_clear = 1'b0;
  logic start_pulse, stop_pulse, irq;
  int total = 0, bad = 0, n_start = 0, n_stop = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  i2c_cond_qualifier i_i2c_cond_qualifier (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .fast_mode(fast_mode), .is_master(is_master), .irq_clear(irq_clear),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .irq(irq)
  );

  always @(negedge clk) begin
    if (start_pulse) n_start++;
    if (stop_pulse)  n_stop++;
  end

  // fast, master, initial SDA, gap to edge 1, gap to edge 2 (0 = none), SCL high after last edge, exp start, exp stop, tag
  typedef struct packed {
    logic fast; logic mst; logic init;
    logic [9:0] n1; logic [9:0] n2; logic [9:0] hh;
    logic [1:0] e_start; logic [1:0] e_stop; logic [3:0] tag;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b1, 10'd26, 10'd0,  10'd20, 2'd0, 2'd0, 4'd3},
    '{1'b0,1'b0,1'b1, 10'd27, 10'd0,  10'd20, 2'd1, 2'd0, 4'd3},
    '{1'b0,1'b0,1'b0, 10'd27, 10'd0,  10'd20, 2'd0, 2'd1, 4'd6},
    '{1'b0,1'b1,1'b0, 10'd40, 10'd0,  10'd20, 2'd0, 2'd1, 4'd8},
    '{1'b0,1'b0,1'b1, 10'd40, 10'd0,  10'd13, 2'd0, 2'd0, 4'd5},
    '{1'b0,1'b0,1'b1, 10'd40, 10'd0,  10'd14, 2'd1, 2'd0, 4'd5},
    '{1'b1,1'b0,1'b1, 10'd4,  10'd0,  10'd10, 2'd0, 2'd0, 4'd3},
    '{1'b1,1'b0,1'b1, 10'd5,  10'd0,  10'd10, 2'd1, 2'd0, 4'd3},
    '{1'b1,1'b0,1'b0, 10'd10, 10'd0,  10'd2,  2'd0, 2'd0, 4'd5},
    '{1'b1,1'b0,1'b0, 10'd10, 10'd0,  10'd3,  2'd0, 2'd1, 4'd5},
    '{1'b0,1'b0,1'b1, 10'd60, 10'd13, 10'd20, 2'd0, 2'd0, 4'd4},
    '{1'b0,1'b0,1'b1, 10'd60, 10'd14, 10'd20, 2'd1, 2'd1, 4'd11},
    '{1'b1,1'b0,1'b0, 10'd10, 10'd2,  10'd5,  2'd0, 2'd0, 4'd4},
    '{1'b1,1'b0,1'b0, 10'd10, 10'd3,  10'd5,  2'd1, 2'd1, 4'd11},
    '{1'b0,1'b0,1'b1, 10'd500,10'd0,  10'd20, 2'd1, 2'd0, 4'd10}
  };

  function automatic string tag_of(input int t);
    case (t)
      3: return "R3";   4: return "R4";   5: return "R5";   6: return "R6";
      8: return "R8";   10: return "R10"; 11: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    @(posedge clk);
    n_start = 0; n_stop = 0;
    @(negedge clk);
    fast_mode = v.fast; is_master = v.mst; sda = v.init;
    repeat (4) @(negedge clk);
    scl = 1'b1;
    repeat (int'(v.n1)) @(negedge clk);
    sda = ~sda;
    if (v.n2 != 0) begin
      repeat (int'(v.n2)) @(negedge clk);
      sda = ~sda;
    end
    repeat (int'(v.hh)) @(negedge clk);
    scl = 1'b0;
    repeat (8) @(negedge clk);
    sda = 1'b1;
  endtask

  initial begin
    // R1: outputs quiet in and right after reset
    repeat (3) @(negedge clk);
    chk("R1 start", int'(start_pulse), 0);
    chk("R1 stop", int'(stop_pulse), 0);
    chk("R1 irq", int'(irq), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 irq after release", int'(irq), 0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i]);
      chk({tag_of(int'(VEC[i].tag)), " start count"}, n_start, int'(VEC[i].e_start));
      chk({tag_of(int'(VEC[i].tag)), " stop count"}, n_stop, int'(VEC[i].e_stop));
      chk("R8 irq level", int'(irq), int'(VEC[i].e_stop != 0 && !VEC[i].mst));
      if (irq) begin
        @(negedge clk); irq_clear = 1'b1;
        @(negedge clk); irq_clear = 1'b0;
        chk("R9 irq cleared", int'(irq), 0);
      end
    end

    // R2: SDA activity with SCL low gives nothing
    @(posedge clk); n_start = 0; n_stop = 0;
    @(negedge clk); fast_mode = 1'b1; scl = 1'b0;
    for (int k = 0; k < 6; k++) begin
      repeat (30) @(negedge clk);
      sda = ~sda;
    end
    repeat (10) @(negedge clk);
    chk("R2 no start with SCL low", n_start, 0);
    chk("R2 no stop with SCL low", n_stop, 0);
    sda = 1'b1;

    // R9: irq holds across a long idle with no clear
    run_vec('{1'b1,1'b0,1'b0, 10'd10, 10'd0, 10'd5, 2'd0, 2'd1, 4'd6});
    repeat (50) @(negedge clk);
    chk("R9 irq held", int'(irq), 1);
    irq_clear = 1'b1; @(negedge clk); irq_clear = 1'b0;
    chk("R9 irq cleared", int'(irq), 0);

    // R12: exact latency in high-speed mode (hold minimum 2 -> 5th rising edge)
    repeat (4) @(negedge clk);
    fast_mode = 1'b1; sda = 1'b1;
    repeat (4) @(negedge clk);
    scl = 1'b1;
    repeat (10) @(negedge clk);
    sda = 1'b0;
    repeat (4) @(negedge clk);
    chk("R12 pulse not yet", int'(start_pulse), 0);
    @(negedge clk);
    chk("R12 pulse on time", int'(start_pulse), 1);
    @(negedge clk);
    chk("R12 pulse one cycle", int'(start_pulse), 0);
    scl = 1'b0;
    repeat (5) @(negedge clk);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule